// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Control

This block is the hazard control of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It looks at the source register numbers of the instruction in decode and of the instruction in execute. It compares them with the destination register numbers, write-enable flags and load flags held in the later pipeline registers. From these comparisons it produces three kinds of control. The first is a forwarding select for each ALU operand. The second is an interlock that holds the front of the pipeline for one cycle behind a load. The third is a squash of wrongly fetched instructions when a branch that was predicted not taken turns out to be taken in execute.

The register file writes in the first half of a cycle and reads in the second half. A producer that is three instructions ahead therefore needs no bypass. Only the two stages just behind the producer are forwarded: the memory-stage register and the write-back-stage register. Every instruction class writes the register file in stage five, so a single write port is enough. The block is purely combinational from its comparison inputs. The clock and reset serve only the embedded assertions.

Top module: `hzu_unit`

## Requirements
- R1: When `mem_wen` is 1, `mem_rd` is nonzero and `mem_rd` equals an execute-stage source, that operand's select is 2'b10 (take the memory-stage result).
- R2: When `wb_wen` is 1, `wb_rd` is nonzero and `wb_rd` equals an execute-stage source, and R1 does not apply, that operand's select is 2'b01 (take the write-back result).
- R3: When both the memory-stage and the write-back-stage destinations match the same source, the select is 2'b10. The younger result wins.
- R4: Register 0 is never a dependency. A source of 0 always gives select 2'b00, and a load whose destination is 0 never causes a stall.
- R5: With no enabled, matching producer, the select is 2'b00 (register file value). A write-enable of 0 suppresses a match.
- R6: A load in execute (`ex_is_load`=1, `ex_wen`=1) whose nonzero `ex_rd` equals `id_rs1` or `id_rs2` raises `hold_front` and `kill_idex` for that cycle, with `kill_ifid`=0. `hold_front` freezes the PC and the fetch/decode register. `kill_idex` loads a no-op with write-enable and memory-write cleared into the decode/execute register.
- R7: A matching execute-stage producer that is not a load, or a load with no matching decode source, raises no stall.
- R8: `ex_br_taken`=1 raises `redirect_pc`, `kill_ifid` and `kill_idex`, and keeps `hold_front`=0.
- R9: When a taken branch and a load-use stall occur in the same cycle, the flush wins. `hold_front`=0, and `kill_ifid`=1 and `kill_idex`=1.
- R10: With no hazard and no taken branch, `hold_front`, `kill_ifid`, `kill_idex` and `redirect_pc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst | input | 1 | Synchronous active-high reset, disables the checks |
| id_rs1 | input | REG_AW | First source register of the decode instruction |
| id_rs2 | input | REG_AW | Second source register of the decode instruction |
| ex_rs1 | input | REG_AW | First source register of the execute instruction |
| ex_rs2 | input | REG_AW | Second source register of the execute instruction |
| ex_rd | input | REG_AW | Destination register of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination register in the memory stage |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | REG_AW | Destination register in the write-back stage |
| wb_wen | input | 1 | Write-back instruction writes a register |
| ex_br_taken | input | 1 | Branch in execute resolved taken |
| fwd_a | output | 2 | Operand A select: 00 register file, 01 write-back, 10 memory stage |
| fwd_b | output | 2 | Operand B select, same encoding |
| hold_front | output | 1 | Freeze PC and fetch/decode register |
| kill_ifid | output | 1 | Squash the fetch/decode register |
| kill_idex | output | 1 | Load a no-op into the decode/execute register |
| redirect_pc | output | 1 | Fetch restarts at the branch target |

## Verification
The bench builds the block with the default REG_AW of 5, so all 32 register numbers exist. Register 31 is used to exercise the full-width compare, and register 0 to exercise the exclusion. The tests place producers at distance one and two from the consumer and make both distances match at once. They pair a load-use hazard with a taken branch in the same cycle, so that the priority of the flush over the stall can be observed at the ports.

// File: rtl/hzu_pkg.sv
package hzu_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic hold_front;
        logic kill_ifid;
        logic kill_idex;
        logic redirect;
    } front_ctl_t;

endpackage

// File: rtl/hzu_fwd_sel.sv
module hzu_fwd_sel
    import hzu_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output fwd_sel_e          sel
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic src_live;
    logic mem_hit;
    logic wb_hit;

    assign src_live = (src != ZERO_REG);
    assign mem_hit  = src_live && mem_wen && (mem_rd == src);
    assign wb_hit   = src_live && wb_wen  && (wb_rd  == src);

    always_comb begin
        if (mem_hit)     sel = FWD_MEM;
        else if (wb_hit) sel = FWD_WB;
        else             sel = FWD_RF;
    end

    // R4: source register 0 never takes a bypass
    p_zero_src_r4: assert property (@(posedge clk) disable iff (rst)
        (src == ZERO_REG) |-> (sel == FWD_RF));

    // R3: memory-stage match overrides write-back match
    p_mem_first_r3: assert property (@(posedge clk) disable iff (rst)
        (src != ZERO_REG && mem_wen && mem_rd == src) |-> (sel == FWD_MEM));

    // R5: disabled producers never drive a bypass
    p_no_wen_r5: assert property (@(posedge clk) disable iff (rst)
        (!mem_wen && !wb_wen) |-> (sel == FWD_RF));

    p_sel_legal_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

endmodule

// File: rtl/hzu_load_use.sv
module hzu_load_use #(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    output logic              hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic load_live;

    assign load_live = ex_is_load && ex_wen && (ex_rd != ZERO_REG);
    assign hit = load_live && ((ex_rd == id_rs1) || (ex_rd == id_rs2));

    // R4: a load into register 0 never interlocks
    p_zero_load_r4: assert property (@(posedge clk) disable iff (rst)
        (ex_rd == ZERO_REG) |-> !hit);

    // R7: non-load producers never interlock
    p_nonload_r7: assert property (@(posedge clk) disable iff (rst)
        !ex_is_load |-> !hit);

endmodule

// File: rtl/hzu_front_ctl.sv
module hzu_front_ctl
    import hzu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_hit,
    input  logic       br_taken,
    output front_ctl_t ctl
);
    always_comb begin
        ctl = '0;
        if (br_taken) begin
            ctl.redirect  = 1'b1;
            ctl.kill_ifid = 1'b1;
            ctl.kill_idex = 1'b1;
        end else if (load_hit) begin
            ctl.hold_front = 1'b1;
            ctl.kill_idex  = 1'b1;
        end
    end

    // R9: a taken branch never leaves the front end frozen
    p_flush_wins_r9: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> (!ctl.hold_front && ctl.kill_ifid));

    // R6: an interlock always comes with a bubble into execute
    p_bubble_r6: assert property (@(posedge clk) disable iff (rst)
        ctl.hold_front |-> (ctl.kill_idex && !ctl.kill_ifid));

    // R10: quiet inputs give quiet controls
    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (!br_taken && !load_hit) |-> (ctl == '0));

endmodule

// File: rtl/hzu_unit.sv
module hzu_unit
    import hzu_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    input  logic              ex_br_taken,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              hold_front,
    output logic              kill_ifid,
    output logic              kill_idex,
    output logic              redirect_pc
);
    localparam int unsigned NUM_OPS = 2;

    logic [REG_AW-1:0] ex_src [NUM_OPS];
    fwd_sel_e          op_sel [NUM_OPS];
    logic              load_hit;
    front_ctl_t        ctl;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hzu_fwd_sel #(.REG_AW(REG_AW)) u_sel (
            .clk     (clk),
            .rst     (rst),
            .src     (ex_src[g]),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_wen),
            .sel     (op_sel[g])
        );
    end

    hzu_load_use #(.REG_AW(REG_AW)) u_lu (
        .clk        (clk),
        .rst        (rst),
        .id_rs1     (id_rs1),
        .id_rs2     (id_rs2),
        .ex_rd      (ex_rd),
        .ex_wen     (ex_wen),
        .ex_is_load (ex_is_load),
        .hit        (load_hit)
    );

    hzu_front_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .load_hit (load_hit),
        .br_taken (ex_br_taken),
        .ctl      (ctl)
    );

    assign fwd_a       = op_sel[0];
    assign fwd_b       = op_sel[1];
    assign hold_front  = ctl.hold_front;
    assign kill_ifid   = ctl.kill_ifid;
    assign kill_idex   = ctl.kill_idex;
    assign redirect_pc = ctl.redirect;

    // R8: taken branch squashes both younger instructions
    p_branch_kill_r8: assert property (@(posedge clk) disable iff (rst)
        ex_br_taken |-> (redirect_pc && kill_ifid && kill_idex));

endmodule

// File: tb/hzu_unit_tb.sv
module hzu_unit_tb;
    localparam int unsigned AW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic ex_wen, ex_is_load, mem_wen, wb_wen, ex_br_taken;
    logic [1:0] fwd_a, fwd_b;
    logic hold_front, kill_ifid, kill_idex, redirect_pc;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hzu_unit #(.REG_AW(AW)) u_dut (
        .clk(clk), .rst(rst),
        .id_rs1(id_rs1), .id_rs2(id_rs2),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
        .ex_wen(ex_wen), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_wen(mem_wen),
        .wb_rd(wb_rd), .wb_wen(wb_wen),
        .ex_br_taken(ex_br_taken),
        .fwd_a(fwd_a), .fwd_b(fwd_b),
        .hold_front(hold_front), .kill_ifid(kill_ifid),
        .kill_idex(kill_idex), .redirect_pc(redirect_pc)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic quiet();
        @(negedge clk);
        id_rs1 = '0; id_rs2 = '0; ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0;
        mem_rd = '0; wb_rd = '0;
        ex_wen = 0; ex_is_load = 0; mem_wen = 0; wb_wen = 0; ex_br_taken = 0;
    endtask

    function automatic int ctl4();
        return {hold_front, kill_ifid, kill_idex, redirect_pc};
    endfunction

    task automatic t_reset();
        quiet(); #2;
        chk("R10 reset fwd_a", fwd_a, 0);
        chk("R10 reset fwd_b", fwd_b, 0);
        chk("R10 reset ctl", ctl4(), 0);
    endtask

    task automatic t_fwd_mem();
        quiet();
        ex_rs1 = 5'd7; ex_rs2 = 5'd31; mem_rd = 5'd31; mem_wen = 1; #2;
        chk("R1 fwd_b mem", fwd_b, 2);
        chk("R1 fwd_a untouched", fwd_a, 0);
    endtask

    task automatic t_fwd_wb();
        quiet();
        ex_rs1 = 5'd9; ex_rs2 = 5'd3; wb_rd = 5'd9; wb_wen = 1;
        mem_rd = 5'd3; mem_wen = 0; #2;
        chk("R2 fwd_a wb", fwd_a, 1);
        chk("R5 fwd_b wen low", fwd_b, 0);
    endtask

    task automatic t_prio();
        quiet();
        ex_rs1 = 5'd12; ex_rs2 = 5'd12; mem_rd = 5'd12; wb_rd = 5'd12;
        mem_wen = 1; wb_wen = 1; #2;
        chk("R3 fwd_a prio", fwd_a, 2);
        chk("R3 fwd_b prio", fwd_b, 2);
    endtask

    task automatic t_zero();
        quiet();
        ex_rs1 = 0; ex_rs2 = 0; mem_rd = 0; wb_rd = 0; mem_wen = 1; wb_wen = 1;
        ex_rd = 0; ex_wen = 1; ex_is_load = 1; id_rs1 = 0; id_rs2 = 0; #2;
        chk("R4 fwd_a r0", fwd_a, 0);
        chk("R4 fwd_b r0", fwd_b, 0);
        chk("R4 no stall r0", hold_front, 0);
    endtask

    task automatic t_nomatch();
        quiet();
        ex_rs1 = 5'd4; ex_rs2 = 5'd5; mem_rd = 5'd6; wb_rd = 5'd8;
        mem_wen = 1; wb_wen = 1; #2;
        chk("R5 fwd_a nomatch", fwd_a, 0);
        chk("R5 fwd_b nomatch", fwd_b, 0);
    endtask

    task automatic t_loaduse();
        quiet();
        ex_rd = 5'd17; ex_wen = 1; ex_is_load = 1; id_rs1 = 5'd2; id_rs2 = 5'd17; #2;
        chk("R6 hold", hold_front, 1);
        chk("R6 kill_idex", kill_idex, 1);
        chk("R6 kill_ifid", kill_ifid, 0);
        chk("R6 redirect", redirect_pc, 0);
        id_rs1 = 5'd17; id_rs2 = 5'd1; #2;
        chk("R6 hold rs1", hold_front, 1);
    endtask

    task automatic t_noload();
        quiet();
        ex_rd = 5'd17; ex_wen = 1; ex_is_load = 0; id_rs1 = 5'd17; #2;
        chk("R7 alu producer", ctl4(), 0);
        ex_is_load = 1; id_rs1 = 5'd16; id_rs2 = 5'd18; #2;
        chk("R7 load no match", ctl4(), 0);
    endtask

    task automatic t_branch();
        quiet();
        ex_br_taken = 1; #2;
        chk("R8 branch ctl", ctl4(), 4'b0111);
    endtask

    task automatic t_flush_vs_stall();
        quiet();
        ex_rd = 5'd20; ex_wen = 1; ex_is_load = 1; id_rs2 = 5'd20; ex_br_taken = 1; #2;
        chk("R9 hold", hold_front, 0);
        chk("R9 kill_ifid", kill_ifid, 1);
        chk("R9 kill_idex", kill_idex, 1);
    endtask

    task automatic t_not_taken();
        quiet();
        ex_rs1 = 5'd3; mem_rd = 5'd3; mem_wen = 1; #2;
        chk("R10 idle ctl", ctl4(), 0);
        chk("R1 fwd while idle", fwd_a, 2);
    endtask

    initial begin
        quiet();
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst = 1'b0;
        t_fwd_mem();
        t_fwd_wb();
        t_prio();
        t_zero();
        t_nomatch();
        t_loaduse();
        t_noload();
        t_branch();
        t_flush_vs_stall();
        t_not_taken();
        quiet();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog got=timeout exp=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule